// File: doc/BRIEF.md
# Dual-Clock Mode-Selected Shift Register

This block is a small register with a parallel-load path and a right-shift path. Each path has its own clock pin. A mode input decides which of the two clocks takes effect. When mode is high, a falling edge on the load clock copies the four parallel inputs into the register. When mode is low, a falling edge on the shift clock moves every stage one place toward the last stage, and the serial input enters the first stage.

The block has no left-shift path of its own. Left shifting is done by wiring each output back to the parallel input of the stage before it, driving the new serial bit on the last parallel input, and pulsing the load clock with mode high. The two clock pins may also be tied to one source, so that the mode input alone picks between load and right shift.

Both clock pins are treated as slow data signals. A two-stage synchronizer brings each one into the system clock domain, and its falling edges are detected there. A synchronous reset is provided for test.

Top module: `dual_clk_shift_reg`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `q` becomes all zeros on that edge.
- R2: With `mode_load` high, a falling edge on `clk_load` copies `par_in` into `q` bit for bit. Bit 0 is the first stage (the one the serial bit enters) and bit 3 is the last stage.
- R3: With `mode_load` low, a falling edge on `clk_shift` sets `q[0]` to `ser_in` and `q[i]` to the old `q[i-1]` for i = 1 to 3.
- R4: In load mode, `ser_in` has no effect on the loaded value.
- R5: A falling edge on `clk_load` while `mode_load` is low, or on `clk_shift` while `mode_load` is high, leaves `q` unchanged.
- R6: Changing `mode_load`, or raising either clock pin, leaves `q` unchanged when no falling edge occurs.
- R7: A pin fall seen at a `clk` edge changes `q` on the third rising edge of `clk` after it, and does so only once, however long the pin stays low. `mode_load`, `par_in` and `ser_in` are sampled on that same edge.
- R8: Applying `par_in = {ser, q[3:1]}` and pulsing `clk_load` with mode high gives `q` = {ser, old q[3:1]}, which is a left shift.
- R9: With both clock pins falling together, mode high performs a load and mode low performs a right shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples everything |
| rst | input | 1 | Synchronous active-high clear |
| mode_load | input | 1 | 1 selects load on `clk_load`; 0 selects right shift on `clk_shift` |
| clk_shift | input | 1 | Shift clock; acts on its falling edge |
| clk_load | input | 1 | Load clock; acts on its falling edge |
| ser_in | input | 1 | Serial bit that enters stage 0 on a right shift |
| par_in | input | 4 | Parallel data; bit i goes to stage i |
| q | output | 4 | Register contents, stage 0 in bit 0 |

## Verification
The hardest case to reach from the ports is an edge that falls on the clock the current mode does not select. It has to leave the register unchanged even though the pin activity matches a real operation. A further hard case is both pins falling in the same cycle, where only the selected operation may act. The random stimulus reaches these cases by picking the mode and the set of falling pins (shift only, load only, or both) independently of each other. Directed steps then hold a pin low for many cycles, toggle the mode while both pins stay idle, and check the exact cycle in which `q` changes.

// File: rtl/dual_clk_shift_reg.sv
module dual_clk_shift_reg #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_load,
  input  logic             clk_shift,
  input  logic             clk_load,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);
  localparam int HIST = SYNC_STAGES + 1;

  logic [HIST-1:0] sh_hist, ld_hist;
  logic            fall_shift, fall_load, do_shift, do_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_hist <= '0;
      ld_hist <= '0;
    end else begin
      sh_hist <= {sh_hist[HIST-2:0], clk_shift};
      ld_hist <= {ld_hist[HIST-2:0], clk_load};
    end
  end

  assign fall_shift = sh_hist[HIST-1] & ~sh_hist[HIST-2];
  assign fall_load  = ld_hist[HIST-1] & ~ld_hist[HIST-2];
  assign do_load    = fall_load & mode_load;
  assign do_shift   = fall_shift & ~mode_load;

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (do_load)  q <= par_in;
    else if (do_shift) q <= {q[WIDTH-2:0], ser_in};
  end

  // R2
  load_path_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_load && mode_load) |=> q == $past(par_in));

  // R3
  shift_path_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_shift && !mode_load) |=> q == {$past(q[WIDTH-2:0]), $past(ser_in)});

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(fall_load && mode_load) && !(fall_shift && !mode_load) |=> $stable(q));

  // R7
  single_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_shift || fall_load) |=> !($past(fall_shift) && fall_shift) && !($past(fall_load) && fall_load));
endmodule

// File: tb/tb_dual_clk_shift_reg.sv
module tb_dual_clk_shift_reg;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 0, rst = 1, mode_load = 0, clk_shift = 1, clk_load = 1, ser_in = 0;
  logic [W-1:0] par_in = '0;
  logic [W-1:0] q;
  logic [W-1:0] exp_q;
  int checks = 0, errors = 0;
  bit done = 0;

  dual_clk_shift_reg dut (.clk(clk), .rst(rst), .mode_load(mode_load), .clk_shift(clk_shift),
    .clk_load(clk_load), .ser_in(ser_in), .par_in(par_in), .q(q));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] model(input logic [W-1:0] cur, input logic m, input logic s,
                                         input logic [W-1:0] p, input bit f1, input bit f2);
    if (m && f2)       return p;
    else if (!m && f1) return {cur[W-2:0], s};
    return cur;
  endfunction

  task automatic check(input string req, input logic [W-1:0] expv);
    checks++;
    if (q !== expv) begin
      errors++;
      $display("FAIL %s q=%b expected=%b", req, q, expv);
    end
  endtask

  task automatic pulse(input bit f1, input bit f2, input string req);
    @(negedge clk);
    if (f1) clk_shift = 0;
    if (f2) clk_load = 0;
    repeat (4) @(negedge clk);
    clk_shift = 1; clk_load = 1;
    repeat (4) @(negedge clk);
    exp_q = model(exp_q, mode_load, ser_in, par_in, f1, f2);
    check(req, exp_q);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    exp_q = '0;
    repeat (3) @(negedge clk);
    check("R1", '0);
    rst = 0;

    // R7 exact latency and single action, with R2 and R4
    mode_load = 1; ser_in = 1; par_in = 4'b1010;
    @(negedge clk); clk_load = 0;
    @(negedge clk); @(negedge clk);
    check("R7", 4'b0000);
    @(negedge clk);
    check("R7", 4'b1010);
    exp_q = 4'b1010;
    par_in = 4'b0101;
    repeat (10) @(negedge clk);
    check("R7", exp_q);
    clk_load = 1; repeat (4) @(negedge clk);
    check("R6", exp_q);

    // R4 serial bit ignored in load mode
    ser_in = 0; par_in = 4'b0111; pulse(0, 1, "R4");
    ser_in = 1; pulse(0, 1, "R4");

    // R6 mode toggling with idle clocks
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); mode_load = ~mode_load;
    end
    repeat (4) @(negedge clk);
    check("R6", exp_q);

    // R5 wrong-clock edges
    mode_load = 1; par_in = 4'b0000; pulse(1, 0, "R5");
    mode_load = 0; par_in = 4'b1111; pulse(0, 1, "R5");

    // R3 shift right
    mode_load = 0; ser_in = 1; pulse(1, 0, "R3");
    ser_in = 0; pulse(1, 0, "R3");

    // R8 left shift via external feedback
    mode_load = 1;
    for (int i = 0; i < 4; i++) begin
      ser_in = 0;
      par_in = {logic'(i[0]), q[W-1:1]};
      pulse(0, 1, "R8");
    end

    // R9 tied clocks
    mode_load = 1; par_in = 4'b1100; pulse(1, 1, "R9");
    mode_load = 0; ser_in = 1; pulse(1, 1, "R9");

    // random mix
    for (int n = 0; n < 150; n++) begin
      int kind;
      @(negedge clk);
      mode_load = 1'($urandom);
      ser_in = 1'($urandom);
      kind = int'($urandom % 4);
      if (kind == 3 && mode_load) begin
        par_in = {1'($urandom), q[W-1:1]};
        pulse(0, 1, "R8");
      end else begin
        par_in = W'($urandom);
        case (kind)
          0: pulse(1, 0, mode_load ? "R5" : "R3");
          1: pulse(0, 1, mode_load ? "R2" : "R5");
          default: pulse(1, 1, "R9");
        endcase
      end
    end

    // R1 reset from nonzero
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    exp_q = '0;
    check("R1", exp_q);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule